// File: doc/BRIEF.md
# Variable refresh vertical timing controller

This block sequences the vertical timing of one display pipe, one scanline at a time. A one-cycle `line_tick` marks the end of each scanline. The block keeps a line counter and raises `vblank` once the active height has been scanned. It then decides on which line vertical blanking ends.

With variable refresh on, the frame length floats between a minimum total and a maximum total. Software asks for an early frame by setting the send bit of the push register. The exit out of blanking starts on the first line inside the allowed window after the push. If no push arrives, the exit is forced at a deadline set by the maximum total. The exit sequence lasts the guardband plus the frame-start delay plus one line. `frame_start` pulses on the last tick of that sequence.

Timing registers are double-buffered. Writes go to a programmed copy, and `reg_latch` copies it into the working set. In variable mode this happens at the exit point. In fixed mode it happens when blanking starts, and the frame then runs to the nominal total.

Top module: `vrr_vtiming`

## Requirements
- R1: Registers read back exactly what was written. The addresses are:
  - 0: control. Bit 0 is the variable-refresh enable, bits 9:8 hold the frame-start delay code, bits 23:16 hold the guardband.
  - 1: minimum total minus one.
  - 2: maximum total minus one.
  - 3: flip line minus one.
  - 4: push. Bit 0 is the enable, bit 1 is the send bit.
  - 5: nominal total minus one.
  - 6: active height.
  - After reset the control register reads 0 and the nominal-total register reads the default total minus one.
- R2: In fixed mode a frame lasts the nominal total in line ticks. `reg_latch` pulses on the tick that enters line active height. A push has no effect on frame length.
- R3: In variable mode the exit length is E = guardband + delay + 1. `reg_latch` pulses on the tick that enters the exit line S, and the frame lasts S + E ticks.
- R4: The earliest exit line is max(flip line, minimum total + 1) − E. A push made before that line, or during the previous frame's exit, is held pending and causes the exit at exactly that line.
- R5: A push written during line P of the window exits at line P + 1.
- R6: With no push the exit line is the maximum total − E, so the frame lasts the maximum total.
- R7: The send bit reads 1 while a push is pending. It clears itself when the exit that consumes it begins, leaving the enable bit set.
- R8: A second push while one is pending has no further effect. A push written with the enable bit clear is ignored and reads back as 0.
- R9: `line_count` is 0 after reset and after every frame start, and increments on each other tick. `vblank` is high exactly while `line_count` ≥ the active height.
- R10: Changes to timing registers take effect at the next `reg_latch`. A change of mode takes effect at the frame start after that. Writing 0 to the control and push registers returns the block to fixed timing.
- R11: Delay codes 0 to 3 select a frame-start delay of 1 to 4 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse at the end of each scanline |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| line_count | output | LINE_W | Current scanline number |
| vblank | output | 1 | Vertical blanking |
| frame_start | output | 1 | Pulses during the tick that ends the frame |
| reg_latch | output | 1 | Pulses during the tick at which the working registers load |

## Verification
`frame_start` and `reg_latch` are combinational from the tick and the register state, so both are due in the very cycle `line_tick` is high. `line_count` and `vblank` move only at the edge that consumes the tick. The bench therefore raises the tick at a falling edge, samples the strobes a moment later, and reads the line state during idle cycles between ticks.

A register write is visible on the read port in the next cycle. A timing change waits for the next latch, and a mode change waits one frame more. For that reason every configuration change is followed by two unchecked frames before any frame length or latch line is compared with the arithmetic model.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

  localparam int ADDR_W      = 3;
  localparam int N_LINE_REGS = 5;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_FSD_LSB = 8;
  localparam int CTRL_GB_LSB  = 16;
  localparam int PUSH_EN_BIT   = 0;
  localparam int PUSH_SEND_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_VMIN = 3'd1,
    RA_VMAX = 3'd2,
    RA_FLIP = 3'd3,
    RA_PUSH = 3'd4,
    RA_VTOT = 3'd5,
    RA_VACT = 3'd6
  } reg_addr_e;

  // slot index of the line-valued registers -> register address
  function automatic logic [ADDR_W-1:0] slot_addr(int i);
    case (i)
      0:       return RA_VMIN;
      1:       return RA_VMAX;
      2:       return RA_FLIP;
      3:       return RA_VTOT;
      default: return RA_VACT;
    endcase
  endfunction

  // lines spent leaving blanking: guardband + (code+1) + 1
  function automatic int unsigned exit_len(int unsigned gb, int unsigned fsd_code);
    return gb + fsd_code + 2;
  endfunction

  // earliest exit line: max(flip, vmin+1) - exit length
  function automatic int unsigned first_exit(int unsigned flip_m1, int unsigned vmin_m1,
                                             int unsigned elen);
    int unsigned flip_l;
    int unsigned vmin_l;
    flip_l = flip_m1 + 1;
    vmin_l = vmin_m1 + 2;
    return ((flip_l > vmin_l) ? flip_l : vmin_l) - elen;
  endfunction

  // forced exit line: vmax - exit length
  function automatic int unsigned last_exit(int unsigned vmax_m1, int unsigned elen);
    return vmax_m1 + 1 - elen;
  endfunction

endpackage

// File: rtl/vrr_push.sv
module vrr_push (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_push,
  input  logic wdata_en,
  input  logic wdata_send,
  input  logic consume,
  output logic push_en,
  output logic push_send
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_en   <= 1'b0;
      push_send <= 1'b0;
    end else begin
      if (wr_push) push_en <= wdata_en;
      if (consume)
        push_send <= 1'b0;
      else if (wr_push)
        push_send <= wdata_en & (wdata_send | push_send);
    end
  end

endmodule

// File: rtl/vrr_regs.sv
module vrr_regs
  import vrr_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int DATA_W      = 32,
  parameter int GB_W        = 8,
  parameter int DEF_VTOTAL  = 20,
  parameter int DEF_VACTIVE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              latch,
  input  logic              push_en,
  input  logic              push_send,
  output logic [DATA_W-1:0] rdata,
  output logic              act_en,
  output logic [GB_W-1:0]   act_gb,
  output logic [1:0]        act_fsd,
  output logic [LINE_W-1:0] act_vmin_m1,
  output logic [LINE_W-1:0] act_vmax_m1,
  output logic [LINE_W-1:0] act_flip_m1,
  output logic [LINE_W-1:0] act_vtotal_m1,
  output logic [LINE_W-1:0] act_vactive
);

  logic [N_LINE_REGS-1:0][LINE_W-1:0] pend_v;
  logic [N_LINE_REGS-1:0][LINE_W-1:0] act_v;

  for (genvar g = 0; g < N_LINE_REGS; g++) begin : g_slot
    localparam int RV = (g == 3) ? DEF_VTOTAL - 1 : (g == 4) ? DEF_VACTIVE : 0;
    logic [LINE_W-1:0] pend_r;
    logic [LINE_W-1:0] act_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_r <= LINE_W'(RV);
        act_r  <= LINE_W'(RV);
      end else begin
        if (wr && addr == slot_addr(g)) pend_r <= wdata[LINE_W-1:0];
        if (latch) act_r <= pend_r;
      end
    end
    assign pend_v[g] = pend_r;
    assign act_v[g]  = act_r;
  end

  logic            pend_en;
  logic [GB_W-1:0] pend_gb;
  logic [1:0]      pend_fsd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_en  <= 1'b0;
      pend_gb  <= '0;
      pend_fsd <= '0;
      act_en   <= 1'b0;
      act_gb   <= '0;
      act_fsd  <= '0;
    end else begin
      if (wr && addr == RA_CTRL) begin
        pend_en  <= wdata[CTRL_EN_BIT];
        pend_fsd <= wdata[CTRL_FSD_LSB +: 2];
        pend_gb  <= wdata[CTRL_GB_LSB +: GB_W];
      end
      if (latch) begin
        act_en  <= pend_en;
        act_gb  <= pend_gb;
        act_fsd <= pend_fsd;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_CTRL) begin
      rdata[CTRL_EN_BIT]           = pend_en;
      rdata[CTRL_FSD_LSB +: 2]     = pend_fsd;
      rdata[CTRL_GB_LSB +: GB_W]   = pend_gb;
    end
    if (addr == RA_PUSH) begin
      rdata[PUSH_EN_BIT]   = push_en;
      rdata[PUSH_SEND_BIT] = push_send;
    end
    for (int i = 0; i < N_LINE_REGS; i++)
      if (addr == slot_addr(i)) rdata = DATA_W'(pend_v[i]);
  end

  assign act_vmin_m1   = act_v[0];
  assign act_vmax_m1   = act_v[1];
  assign act_flip_m1   = act_v[2];
  assign act_vtotal_m1 = act_v[3];
  assign act_vactive   = act_v[4];

endmodule

// File: rtl/vrr_line_seq.sv
module vrr_line_seq
  import vrr_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int GB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              cfg_en,
  input  logic [GB_W-1:0]   cfg_gb,
  input  logic [1:0]        cfg_fsd,
  input  logic [LINE_W-1:0] vmin_m1,
  input  logic [LINE_W-1:0] vmax_m1,
  input  logic [LINE_W-1:0] flip_m1,
  input  logic [LINE_W-1:0] vtotal_m1,
  input  logic [LINE_W-1:0] vactive,
  input  logic              push_pend,
  output logic [LINE_W-1:0] line_count,
  output logic              vblank,
  output logic              frame_start,
  output logic              reg_latch,
  output logic              exit_go,
  output logic              vrr_frame,
  output logic [LINE_W-1:0] win_lo,
  output logic [LINE_W-1:0] win_hi
);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] end_q;
  logic              exiting_q;
  logic              vrr_q;

  logic [LINE_W-1:0] nxt;
  logic [LINE_W-1:0] elen;
  logic              vrr_fs;
  logic              fix_fs;
  logic              fix_latch;

  always_comb begin
    nxt    = line_q + 1'b1;
    elen   = LINE_W'(exit_len(32'(cfg_gb), 32'(cfg_fsd)));
    win_lo = LINE_W'(first_exit(32'(flip_m1), 32'(vmin_m1), 32'(elen)));
    win_hi = LINE_W'(last_exit(32'(vmax_m1), 32'(elen)));
  end

  // decisions are taken on the line being entered
  assign exit_go   = line_tick && vrr_q && !exiting_q && (nxt >= win_lo) &&
                     (push_pend || nxt >= win_hi);
  assign vrr_fs    = line_tick && vrr_q && exiting_q && (line_q >= end_q);
  assign fix_fs    = line_tick && !vrr_q && (line_q >= vtotal_m1);
  assign fix_latch = line_tick && !vrr_q && (nxt == vactive);

  assign frame_start = vrr_fs || fix_fs;
  assign reg_latch   = exit_go || fix_latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= '0;
      end_q     <= '0;
      exiting_q <= 1'b0;
      vrr_q     <= 1'b0;
    end else if (line_tick) begin
      if (frame_start) begin
        line_q    <= '0;
        exiting_q <= 1'b0;
        vrr_q     <= cfg_en;
      end else begin
        line_q <= nxt;
        if (exit_go) begin
          exiting_q <= 1'b1;
          end_q     <= nxt + elen - 1'b1;
        end
      end
    end
  end

  assign line_count = line_q;
  assign vblank     = line_q >= vactive;
  assign vrr_frame  = vrr_q;

endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming
  import vrr_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int DATA_W      = 32,
  parameter int GB_W        = 8,
  parameter int DEF_VTOTAL  = 20,
  parameter int DEF_VACTIVE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [LINE_W-1:0] line_count,
  output logic              vblank,
  output logic              frame_start,
  output logic              reg_latch
);

  logic              act_en;
  logic [GB_W-1:0]   act_gb;
  logic [1:0]        act_fsd;
  logic [LINE_W-1:0] act_vmin_m1;
  logic [LINE_W-1:0] act_vmax_m1;
  logic [LINE_W-1:0] act_flip_m1;
  logic [LINE_W-1:0] act_vtotal_m1;
  logic [LINE_W-1:0] act_vactive;
  logic              push_en;
  logic              push_send;
  logic              push_pend;
  logic              push_consume;
  logic              exit_go;
  logic              vrr_frame;
  logic [LINE_W-1:0] win_lo;
  logic [LINE_W-1:0] win_hi;
  logic              wr_push;

  assign wr_push      = reg_wr && reg_addr == RA_PUSH;
  assign push_pend    = push_en && push_send;
  assign push_consume = exit_go && push_pend;

  vrr_regs #(
    .LINE_W(LINE_W), .DATA_W(DATA_W), .GB_W(GB_W),
    .DEF_VTOTAL(DEF_VTOTAL), .DEF_VACTIVE(DEF_VACTIVE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .latch(reg_latch), .push_en(push_en), .push_send(push_send), .rdata(reg_rdata),
    .act_en(act_en), .act_gb(act_gb), .act_fsd(act_fsd),
    .act_vmin_m1(act_vmin_m1), .act_vmax_m1(act_vmax_m1), .act_flip_m1(act_flip_m1),
    .act_vtotal_m1(act_vtotal_m1), .act_vactive(act_vactive)
  );

  vrr_push u_push (
    .clk(clk), .rst_n(rst_n), .wr_push(wr_push),
    .wdata_en(reg_wdata[PUSH_EN_BIT]), .wdata_send(reg_wdata[PUSH_SEND_BIT]),
    .consume(push_consume), .push_en(push_en), .push_send(push_send)
  );

  vrr_line_seq #(.LINE_W(LINE_W), .GB_W(GB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .cfg_en(act_en), .cfg_gb(act_gb), .cfg_fsd(act_fsd),
    .vmin_m1(act_vmin_m1), .vmax_m1(act_vmax_m1), .flip_m1(act_flip_m1),
    .vtotal_m1(act_vtotal_m1), .vactive(act_vactive), .push_pend(push_pend),
    .line_count(line_count), .vblank(vblank), .frame_start(frame_start),
    .reg_latch(reg_latch), .exit_go(exit_go), .vrr_frame(vrr_frame),
    .win_lo(win_lo), .win_hi(win_hi)
  );

endmodule

// File: rtl/vrr_vtiming_chk.sv
module vrr_vtiming_chk
  import vrr_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LINE_W-1:0] line_count,
  input logic              vblank,
  input logic              frame_start,
  input logic              exit_go,
  input logic              push_consume,
  input logic              push_send,
  input logic [LINE_W-1:0] win_lo,
  input logic [LINE_W-1:0] win_hi
);

  // R6: an exit never starts past the forced deadline
  p_exit_by_deadline_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_go && (win_lo <= win_hi) |-> LINE_W'(line_count + 1'b1) <= win_hi);

  // R7: a consumed push leaves the send bit clear
  p_send_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_consume |=> !push_send);

  // R8: a pending push stays pending until consumed or rewritten
  p_send_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_send && !push_consume && !(reg_wr && reg_addr == RA_PUSH) |=> push_send);

  // R9: the counter restarts after frame start
  p_line_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_count == '0);

  // R9: frames only end from inside blanking
  p_fs_in_vblank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> vblank);

endmodule

bind vrr_vtiming vrr_vtiming_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .line_count(line_count), .vblank(vblank), .frame_start(frame_start),
  .exit_go(exit_go), .push_consume(push_consume), .push_send(push_send),
  .win_lo(win_lo), .win_hi(win_hi)
);

// File: tb/sim_vrr_vtiming.sv
module sim_vrr_vtiming;
  import vrr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W     = 12;
  localparam int VACT       = 8;
  localparam int VTOT       = 12;
  localparam int VMIN       = 12;
  localparam int VMAX       = 24;
  localparam int FLIP       = 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_tick = 1'b0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [LINE_W-1:0] line_count;
  logic              vblank;
  logic              frame_start;
  logic              reg_latch;

  int n_vec = 0;
  int n_bad = 0;

  vrr_vtiming #(.LINE_W(LINE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_count(line_count), .vblank(vblank), .frame_start(frame_start),
    .reg_latch(reg_latch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(output bit fs, output bit lt);
    @(negedge clk);
    line_tick = 1'b1;
    #1 fs = frame_start; lt = reg_latch;
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  // runs one frame from line 0; pushes value pval during lines p1 and p2
  task automatic run_frame(int p1, int p2, logic [31:0] pval, bit line_chk,
                           output int total, output int lat);
    logic [31:0] d;
    bit fs, lt;
    total = -1; lat = -1;
    for (int l = 0; l < 64; l++) begin
      if (l == p1 || l == p2) begin
        wr(RA_PUSH, pval);
        if (pval == 32'd3) begin
          rd(RA_PUSH, d);
          chk(d[1:0] == 2'b11, "R7 send pending", int'(d), 3);
        end
      end
      if (line_chk) begin
        chk(int'(line_count) == l, "R9 line count", int'(line_count), l);
        chk(vblank == (l >= VACT), "R9 vblank", int'(vblank), int'(l >= VACT));
      end
      tick(fs, lt);
      if (lt) lat = l + 1;
      if (fs) begin
        total = l + 1;
        break;
      end
    end
    if (total < 0) chk(1'b0, "R9 frame end", total, 0);
  endtask

  function automatic int exp_start(int p, int ear, int lst);
    int s;
    if (p < 0) return lst;
    s = p + 1;
    if (s < ear) s = ear;
    if (s > lst) s = lst;
    return s;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int t, la, e, ear, lst, s;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(RA_CTRL, d);  chk(d == 0, "R1 ctrl reset", int'(d), 0);
    rd(RA_VTOT, d);  chk(d == 19, "R1 nominal reset", int'(d), 19);
    chk(line_count == 0, "R9 reset line", int'(line_count), 0);
    chk(!vblank, "R9 reset vblank", int'(vblank), 0);
    chk(!frame_start, "R9 reset frame start", int'(frame_start), 0);

    // programming and readback in minus-one form
    wr(RA_VTOT, VTOT - 1); wr(RA_VACT, VACT);
    wr(RA_VMIN, VMIN - 1); wr(RA_VMAX, VMAX - 1); wr(RA_FLIP, FLIP - 1);
    rd(RA_VTOT, d); chk(d + 1 == VTOT, "R1 nominal readback", int'(d) + 1, VTOT);
    rd(RA_VACT, d); chk(d == VACT, "R1 active readback", int'(d), VACT);
    rd(RA_VMIN, d); chk(d + 1 == VMIN, "R1 vmin readback", int'(d) + 1, VMIN);
    rd(RA_VMAX, d); chk(d + 1 == VMAX, "R1 vmax readback", int'(d) + 1, VMAX);
    rd(RA_FLIP, d); chk(d + 1 == FLIP, "R1 flip readback", int'(d) + 1, FLIP);

    // fixed timing
    run_frame(-1, -1, 0, 1'b0, t, la);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == VTOT, "R2 fixed total", t, VTOT);
    chk(la == VACT, "R2 fixed latch line", la, VACT);
    run_frame(2, -1, 3, 1'b1, t, la);
    chk(t == VTOT, "R2 push ignored in fixed mode", t, VTOT);
    wr(RA_PUSH, 0);

    // sweep of guardband and frame-start delay codes (R11)
    for (int gb = 1; gb <= 2; gb++) begin
      for (int code = 0; code < 4; code++) begin
        wr(RA_CTRL, 32'(1 | (code << CTRL_FSD_LSB) | (gb << CTRL_GB_LSB)));
        rd(RA_CTRL, d);
        chk(d == 32'(1 | (code << 8) | (gb << 16)), "R1 ctrl readback", int'(d),
            1 | (code << 8) | (gb << 16));
        run_frame(-1, -1, 0, 1'b0, t, la);
        run_frame(-1, -1, 0, 1'b0, t, la);
        e   = gb + (code + 1) + 1;
        ear = ((FLIP > VMIN + 1) ? FLIP : VMIN + 1) - e;
        lst = VMAX - e;
        run_frame(-1, -1, 0, 1'b1, t, la);
        chk(t == VMAX, "R6 R11 no-push total", t, VMAX);
        chk(la == lst, "R3 R6 deadline latch line", la, lst);
        for (int p = 0; p < lst; p++) begin
          run_frame(p, -1, 3, 1'b1, t, la);
          s = exp_start(p, ear, lst);
          if (p + 1 < ear) chk(t == s + e, "R4 R11 early push total", t, s + e);
          else             chk(t == s + e, "R5 R11 window push total", t, s + e);
          chk(la == s, "R3 exit latch line", la, s);
          rd(RA_PUSH, d);
          chk(d == 1, "R7 send self-clears", int'(d), 1);
        end
      end
    end

    // last config: guardband 2, delay 4 -> E = 7, earliest 6, deadline 17
    e = 7; ear = 6; lst = 17;
    run_frame(0, 1, 3, 1'b1, t, la);
    chk(t == ear + e, "R8 double push total", t, ear + e);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == VMAX, "R8 no second frame from double push", t, VMAX);
    run_frame(0, -1, 2, 1'b1, t, la);
    chk(t == VMAX, "R8 push without enable ignored", t, VMAX);
    rd(RA_PUSH, d);
    chk(d == 0, "R8 push without enable readback", int'(d), 0);

    // push during the exit stays pending for the next frame
    run_frame(lst + 1, -1, 3, 1'b1, t, la);
    chk(t == VMAX, "R4 push during exit", t, VMAX);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == ear + e, "R4 held push taken at earliest", t, ear + e);
    chk(la == ear, "R4 held push latch line", la, ear);

    // flip line below and above vmin+1
    wr(RA_FLIP, 9);
    run_frame(-1, -1, 0, 1'b0, t, la); run_frame(-1, -1, 0, 1'b0, t, la);
    run_frame(0, -1, 3, 1'b1, t, la);
    chk(t == VMIN + 1, "R4 flip below vmin+1", t, VMIN + 1);
    wr(RA_FLIP, 15);
    run_frame(-1, -1, 0, 1'b0, t, la); run_frame(-1, -1, 0, 1'b0, t, la);
    run_frame(0, -1, 3, 1'b1, t, la);
    chk(t == 16, "R4 flip above vmin+1", t, 16);
    wr(RA_FLIP, FLIP - 1);
    run_frame(-1, -1, 0, 1'b0, t, la);

    // R10: new maximum applies only after the latch
    wr(RA_VMAX, 19);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == VMAX, "R10 old max until latch", t, VMAX);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == 20, "R10 new max after latch", t, 20);

    // R10: back to fixed timing
    wr(RA_CTRL, 0); wr(RA_PUSH, 0);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == 20, "R10 disable waits for frame", t, 20);
    run_frame(-1, -1, 0, 1'b1, t, la);
    chk(t == VTOT, "R10 fixed total after disable", t, VTOT);
    chk(la == VACT, "R10 fixed latch after disable", la, VACT);

    finish_run();
  end

endmodule